// File: doc/BRIEF.md
# CCD Line and Frame Readout Sequencer

This block drives the readout of one frame from a full-frame CCD once integration has ended. A single-cycle start request launches the frame. Each line opens with one or more vertical charge transfers, made of two overlapping vertical phase pulses. After a short settle gap, the pixel generator is enabled for a programmed number of pixel slots. Lines repeat until the programmed frame height has been read, and the block then returns to idle with a one-cycle completion pulse.

Two mode inputs cover two sensor families. One input picks the phase pulse width: narrow (64 clocks) or wide (100 clocks). The other picks which vertical phase leads. Vertical binning is done by repeating the transfer pair a programmed number of times before any pixel of the line is read. The geometry and mode inputs are captured when the frame starts. Two active-low strobes mark the pixel window of each line and the span of the whole frame.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, and while idle, v1, v2, pix_run and done are 0, and line_n and frame_n are 1.
- R2: A start_req sampled high while idle starts the first vertical transfer in the next cycle, and frame_n goes low in that same cycle.
- R3: A vertical transfer lasts W + W/2 cycles. The leading phase is high for its first W cycles. The lagging phase is high from cycle W/2 to the end of the transfer. W is 64 when vwide is 0 and 100 when vwide is 1.
- R4: With vswap = 0, v1 is the leading phase and v2 the lagging phase. With vswap = 1 the roles are exchanged.
- R5: Each line begins with B back-to-back transfers, where B is vbin. A vbin of 0 acts as 1.
- R6: The last transfer of a line is followed by exactly 2 cycles in which v1, v2 and pix_run are all 0, and frame_n stays low.
- R7: Each line then holds pix_run high for exactly P consecutive cycles, where P is pix_count (0 acts as 1). line_n is low in exactly those cycles.
- R8: A frame is N lines, where N is line_count (0 acts as 1), read back to back. frame_n is low from the first transfer of line 0 through the last pixel cycle of line N-1.
- R9: done is high for exactly one cycle, immediately after the last pixel cycle of the frame, and the block is idle in the following cycle.
- R10: A start_req during a frame is ignored. Changes to pix_count, line_count, vbin, vswap or vwide during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (one t per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to read out one frame |
| pix_count | input | PIX_W | Pixel slots per line |
| line_count | input | LINE_W | Lines per frame |
| vbin | input | BIN_W | Vertical transfers per line (binning factor) |
| vswap | input | 1 | 0: v1 leads, 1: v2 leads |
| vwide | input | 1 | 0: narrow phase width, 1: wide phase width |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| pix_run | output | 1 | Enable for the pixel generator |
| line_n | output | 1 | Active-low line strobe |
| frame_n | output | 1 | Active-low frame strobe |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The embedded assertions check the following on every cycle:
- the two phases overlap, with the lagging phase rising only while the leading phase is high;
- no vertical phase is active while pixels run;
- the frame strobe covers every pixel cycle;
- done is a single cycle that follows a pixel cycle;
- captured geometry is stable for the whole frame.

The exact pulse widths, the phase order, the binning repeat count, the settle gap length and the pixel and line totals depend on cycle counting across a whole frame. Only the bench's frame sweeps can show them, by comparing every output in every cycle against arithmetic expectations. The same applies to proving that a mid-frame start or input change is ignored.

// File: rtl/ccd_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the CCD readout sequencer.
// Assumes: used by ccd_readout_seq only.
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_VXFER  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_PIXEL  = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ccd_tally.sv
`timescale 1ns/1ps
// Module: ccd_tally
// Modulo counter with a runtime limit. It flags the final count so that a
// controller can tell when a repeated unit (bin, pixel, line) is the last one.
// Assumes: limit >= 1 whenever step is used, and limit is held stable while counting.
module ccd_tally #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         last
);

    logic [W-1:0] cnt_q;

    assign last = (cnt_q == limit - W'(1));

    // Advance on step, wrap after the final count, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= last ? '0 : cnt_q + W'(1);
        end
    end

    a_r5_tally_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/ccd_vphase_gen.sv
`timescale 1ns/1ps
// Module: ccd_vphase_gen
// Produces one vertical transfer of two overlapping phase pulses. The leading
// phase is high for W cycles and the lagging phase rises W/2 cycles in; the
// transfer spans W + W/2 cycles and repeats while active stays high.
// Assumes: wide and swap are held stable while active.
module ccd_vphase_gen #(
    parameter int VW_NARROW = 64,
    parameter int VW_WIDE   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic wide,
    input  logic swap,
    output logic v1,
    output logic v2,
    output logic span_last
);

    localparam int LEN_MAX = VW_WIDE + VW_WIDE / 2;
    localparam int CW      = $clog2(LEN_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] width;
    logic [CW-1:0] span_len;
    logic          lead;
    logic          lag;

    // Pick the phase width for the selected sensor family.
    always_comb begin
        width    = wide ? CW'(VW_WIDE) : CW'(VW_NARROW);
        span_len = width + (width >> 1);
    end

    assign span_last = active && (cnt_q == span_len - CW'(1));
    assign lead      = active && (cnt_q < width);
    assign lag       = active && (cnt_q >= (width >> 1));
    assign v1        = swap ? lag : lead;
    assign v2        = swap ? lead : lag;

    // Position within the current transfer; held at zero when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= span_last ? '0 : cnt_q + CW'(1);
        end
    end

    a_r3_lag_rises_in_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lag) |-> lead);
    a_r3_lead_falls_under_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $fell(lead)) |-> lag);

endmodule

// File: rtl/ccd_readout_seq.sv
`timescale 1ns/1ps
// Module: ccd_readout_seq
// Frame readout sequencer for a full-frame CCD. For each line it runs the
// vertical transfers (repeated for binning), waits a settle gap, then enables
// the pixel generator for the programmed pixel count. It repeats for the
// programmed number of lines and then pulses done.
// Assumes: the pixel waveforms are made elsewhere from pix_run; zero geometry
// values are read as one; start requests arriving mid-frame are dropped.
module ccd_readout_seq #(
    parameter int PIX_W     = 12,
    parameter int LINE_W    = 12,
    parameter int BIN_W     = 4,
    parameter int VW_NARROW = 64,
    parameter int VW_WIDE   = 100,
    parameter int SETTLE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [PIX_W-1:0]  pix_count,
    input  logic [LINE_W-1:0] line_count,
    input  logic [BIN_W-1:0]  vbin,
    input  logic              vswap,
    input  logic              vwide,
    output logic              v1,
    output logic              v2,
    output logic              pix_run,
    output logic              line_n,
    output logic              frame_n,
    output logic              done
);
    import ccd_seq_pkg::*;

    localparam int SW = $clog2(SETTLE + 1);

    seq_state_e        state_q;
    logic [PIX_W-1:0]  pix_lim_q;
    logic [LINE_W-1:0] line_lim_q;
    logic [BIN_W-1:0]  bin_lim_q;
    logic              swap_q;
    logic              wide_q;
    logic [SW-1:0]     settle_q;
    logic              launch;
    logic              span_last;
    logic              bin_last;
    logic              pix_last;
    logic              line_last;

    assign launch = (state_q == ST_IDLE) && start_req;

    ccd_vphase_gen #(
        .VW_NARROW (VW_NARROW),
        .VW_WIDE   (VW_WIDE)
    ) vphase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_VXFER),
        .wide      (wide_q),
        .swap      (swap_q),
        .v1        (v1),
        .v2        (v2),
        .span_last (span_last)
    );

    ccd_tally #(.W(BIN_W)) bin_tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .step  (span_last),
        .limit (bin_lim_q),
        .last  (bin_last)
    );

    ccd_tally #(.W(PIX_W)) pix_tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .step  (state_q == ST_PIXEL),
        .limit (pix_lim_q),
        .last  (pix_last)
    );

    ccd_tally #(.W(LINE_W)) line_tally_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .step  ((state_q == ST_PIXEL) && pix_last),
        .limit (line_lim_q),
        .last  (line_last)
    );

    // Capture geometry and mode at frame start, reading zero values as one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_lim_q  <= PIX_W'(1);
            line_lim_q <= LINE_W'(1);
            bin_lim_q  <= BIN_W'(1);
            swap_q     <= 1'b0;
            wide_q     <= 1'b0;
        end else if (launch) begin
            pix_lim_q  <= (pix_count  == '0) ? PIX_W'(1)  : pix_count;
            line_lim_q <= (line_count == '0) ? LINE_W'(1) : line_count;
            bin_lim_q  <= (vbin       == '0) ? BIN_W'(1)  : vbin;
            swap_q     <= vswap;
            wide_q     <= vwide;
        end
    end

    // Line and frame sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            settle_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE:   if (start_req) state_q <= ST_VXFER;
                ST_VXFER:  if (span_last && bin_last) begin
                               state_q  <= ST_SETTLE;
                               settle_q <= '0;
                           end
                ST_SETTLE: if (settle_q == SW'(SETTLE - 1)) state_q <= ST_PIXEL;
                           else settle_q <= settle_q + SW'(1);
                ST_PIXEL:  if (pix_last) state_q <= line_last ? ST_DONE : ST_VXFER;
                ST_DONE:   state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the strobes from the sequencing state.
    always_comb begin
        pix_run = (state_q == ST_PIXEL);
        line_n  = (state_q != ST_PIXEL);
        frame_n = !((state_q == ST_VXFER) || (state_q == ST_SETTLE) || (state_q == ST_PIXEL));
        done    = (state_q == ST_DONE);
    end

    a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!frame_n && (v1 || v2)));
    a_r6_quiet_phases_in_pixels: assert property (@(posedge clk) disable iff (!rst_n)
        pix_run |-> (!v1 && !v2));
    a_r8_frame_covers_pixels: assert property (@(posedge clk) disable iff (!rst_n)
        pix_run |-> !frame_n);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_after_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pix_run));
    a_r10_geometry_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE))
            |-> ($stable(pix_lim_q) && $stable(line_lim_q) && $stable(bin_lim_q)
                 && $stable(swap_q) && $stable(wide_q)));

endmodule

// File: tb/ccd_readout_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps small geometries across both phase widths and both phase
// orders, and compares every output in every cycle with arithmetic expectations.
module ccd_readout_seq_tb_top;

    localparam int PIX_W  = 12;
    localparam int LINE_W = 12;
    localparam int BIN_W  = 4;
    localparam int SETTLE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_req = 1'b0;
    logic [PIX_W-1:0]  pix_count = '0;
    logic [LINE_W-1:0] line_count = '0;
    logic [BIN_W-1:0]  vbin = '0;
    logic              vswap = 1'b0;
    logic              vwide = 1'b0;
    logic v1, v2, pix_run, line_n, frame_n, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ccd_readout_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .pix_count(pix_count), .line_count(line_count), .vbin(vbin),
        .vswap(vswap), .vwide(vwide),
        .v1(v1), .v2(v2), .pix_run(pix_run), .line_n(line_n),
        .frame_n(frame_n), .done(done)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Compare the six outputs with the expected vector {v1,v2,pix,line_n,frame_n,done}.
    task automatic check_vec(input logic [5:0] exp, input string ctx);
        logic [5:0] act;
        act = {v1, v2, pix_run, line_n, frame_n, done};
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            if (act[5:4] !== exp[5:4])
                $display("FAIL R3/R4/R5 %s: phases actual %b expected %b", ctx, act[5:4], exp[5:4]);
            if (act[3:2] !== exp[3:2])
                $display("FAIL R6/R7 %s: pix_run,line_n actual %b expected %b", ctx, act[3:2], exp[3:2]);
            if (act[1] !== exp[1])
                $display("FAIL R8 %s: frame_n actual %b expected %b", ctx, act[1], exp[1]);
            if (act[0] !== exp[0])
                $display("FAIL R9 %s: done actual %b expected %b", ctx, act[0], exp[0]);
        end
    endtask

    // Run one frame; with disturb set, poke start and change inputs mid-frame (R10).
    task automatic run_frame(input bit swp, input bit wde, input int b, input int p,
                             input int n, input bit disturb);
        int w, span, be, pe, ne, llen, total;
        logic [5:0] exp;
        w    = wde ? 100 : 64;
        span = w + w / 2;
        be   = (b == 0) ? 1 : b;
        pe   = (p == 0) ? 1 : p;
        ne   = (n == 0) ? 1 : n;
        llen = be * span + SETTLE + pe;
        total = ne * llen;
        @(negedge clk);
        vswap = swp; vwide = wde; vbin = BIN_W'(b);
        pix_count = PIX_W'(p); line_count = LINE_W'(n);
        start_req = 1'b1;
        for (int k = 0; k <= total + 3; k++) begin
            @(negedge clk);
            start_req = 1'b0;
            if (disturb && k == 10) begin
                start_req = 1'b1;
                pix_count = PIX_W'(p + 2); line_count = LINE_W'(n + 1);
                vbin = BIN_W'(b + 1); vswap = ~swp; vwide = ~wde;
            end
            if (k < total) begin
                int o, x;
                bit lead, lag;
                o = k % llen;
                if (o < be * span) begin
                    x = o % span;
                    lead = (x < w);
                    lag  = (x >= w / 2);
                    exp = {swp ? lag : lead, swp ? lead : lag, 1'b0, 1'b1, 1'b0, 1'b0};
                end else if (o < be * span + SETTLE) begin
                    exp = 6'b000100;
                end else begin
                    exp = 6'b001000;
                end
            end else if (k == total) begin
                exp = 6'b000111;
            end else begin
                exp = 6'b000110;
            end
            // Mid-frame start ignored and idle afterwards: R10, R2, R1.
            check_vec(exp, $sformatf("swap=%0d wide=%0d b=%0d p=%0d n=%0d k=%0d", swp, wde, b, p, n, k));
        end
        start_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset, even with start low for a few cycles.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_vec(6'b000110, "R1 reset idle");
        end
        // Sweep: R3 width, R4 order, R5 binning, R7 pixels, R8 lines (zeros read as one).
        for (int s = 0; s < 2; s++)
            for (int wv = 0; wv < 2; wv++)
                for (int bi = 0; bi < 2; bi++)
                    for (int pi = 0; pi < 2; pi++)
                        for (int ni = 0; ni < 2; ni++)
                            run_frame(s[0], wv[0], bi * 2, pi * 3, ni * 2, 1'b0);
        // R10: mid-frame start and input changes have no effect.
        run_frame(1'b0, 1'b0, 3, 5, 3, 1'b1);
        run_frame(1'b1, 1'b1, 1, 4, 2, 1'b1);
        // R6/R7: a one-pixel, one-line frame back to back.
        run_frame(1'b0, 1'b1, 1, 1, 1, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule